// File: doc/BRIEF.md
# At-Speed Transition Scan Sequencer

This block runs one two-pattern transition-delay scan test from a fast reference clock. It drives a scan-enable level and a test-clock pulse enable, asserted for single reference cycles. A clock-gating cell downstream turns that enable into clock pulses for the scan flip-flops. Before asserting `start`, software sets the chain length, the shift-rate divider and the launch style. The configuration is latched when `start` is accepted.

A test runs through these states in order:
- IDLE: waiting for `start`.
- LOAD: shifts the first pattern in at the slow rate, with scan-enable high.
- LAUNCH: used only in launch-on-capture mode. Scan-enable is low, and after a settle interval a launch pulse is issued.
- CAPT: a single at-speed capture pulse, one reference period after the launch.
- UNLOAD: scan-enable is high again, and the response is shifted out at the slow rate while the outside streams the next pattern in.
- DONE: one cycle with `done` high, then back to IDLE.

The transitions are:
- IDLE to LOAD on an accepted start.
- LOAD to LAUNCH after the last load pulse in launch-on-capture mode.
- LOAD to CAPT after the last load pulse in launch-on-shift mode. The final shift pulse is then the launch pulse.
- LAUNCH to CAPT after the launch pulse.
- CAPT to UNLOAD.
- UNLOAD to DONE after the last unload pulse.
- DONE to IDLE.
- Any state to IDLE on abort.

When the scan-enable network outside the block has a register pipeline, the block can announce the falling edge of scan-enable early by the pipeline depth. The flip-flops then still see scan-enable drop between the last load pulse and the next pulse.

Top module: `atspeed_scan_seq`

## Requirements
- R1: After reset and while IDLE, `scan_en`, `tclk_en` and `done` are 0 and `shift_cnt` holds its last value (0 after reset).
- R2: `start` is accepted in IDLE only when all of the following hold: `cfg_len` ≥ 1, `cfg_div` ≥ 2, and, if `cfg_pipe`=1, `cfg_div` > SE_PIPE. Any other start is ignored. The configuration is latched at acceptance, so later changes to the cfg inputs have no effect on the running test.
- R3: LOAD starts in cycle 0, the cycle after the accepted start. In LOAD, `scan_en`=1 and exactly L pulses occur, at cycles j·D−1 for j=1..L, where L is the length and D is the divider.
- R4: With `cfg_los`=0 (launch-on-capture), `scan_en` is 0 from cycle T+1, where T=L·D−1. The launch pulse is at cycle T+D, and the capture pulse is at T+D+1, with `scan_en` still 0.
- R5: With `cfg_los`=1 (launch-on-shift), the pulse at cycle T is the launch pulse. The capture pulse follows at T+1 with `scan_en`=0, and no other pulse lies between them.
- R6: With `cfg_pipe`=1, `scan_en` falls SE_PIPE cycles earlier, at cycle T+1−SE_PIPE. Its rising edge after capture is not moved.
- R7: Let C be the capture cycle. `scan_en`=1 from C+1 through C+L·D, and the L unload pulses occur at cycles C+j·D.
- R8: `done` is high for exactly one cycle, at C+L·D+1. In that cycle `shift_cnt` equals L, and the block is IDLE afterwards.
- R9: A `start` that arrives while the block is not IDLE has no effect. The whole test issues exactly 2L+1 pulses for launch-on-shift and 2L+2 pulses for launch-on-capture.
- R10: In any cycle where `abort`=1, `scan_en` and `tclk_en` are 0. From the next cycle the block is IDLE with `shift_cnt`=0 and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test (accepted in IDLE only) |
| abort | input | 1 | Synchronous abort to IDLE |
| cfg_len | input | LEN_W | Chain length in shift pulses |
| cfg_div | input | DIV_W | Reference cycles per shift pulse |
| cfg_los | input | 1 | 1 = launch-on-shift, 0 = launch-on-capture |
| cfg_pipe | input | 1 | 1 = announce the scan-enable fall SE_PIPE cycles early |
| scan_en | output | 1 | Scan-enable level |
| tclk_en | output | 1 | Test-clock pulse enable for this cycle |
| done | output | 1 | One-cycle end-of-test pulse |
| shift_cnt | output | LEN_W | Shift pulses issued in the current load or unload |

## Verification
A wrong state or a wrong divider count appears at the ports in the same cycle. It shows up as a pulse on `tclk_en` at the wrong cycle index, or as `scan_en` at the wrong level. The bench compares both outputs in every cycle from the accepted start through a few cycles past `done`, against a timeline computed from L, D, the mode and the pipeline option. An error in the shift counter therefore shows up no later than the next pulse that should or should not exist. A missed exit from a phase shows up at the next phase boundary. A restart that should have been ignored shifts the whole timeline and the pulse total.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
package scan_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LAUNCH,
        ST_CAPT,
        ST_UNLOAD,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/seq_cfg_hold.sv
`timescale 1ns/1ps
module seq_cfg_hold #(
    parameter int LEN_W   = 8,
    parameter int DIV_W   = 4,
    parameter int SE_PIPE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_los,
    input  logic             cfg_pipe,
    output logic             cfg_ok,
    output logic [LEN_W-1:0] len_q,
    output logic [DIV_W-1:0] div_q,
    output logic             los_q,
    output logic [DIV_W-1:0] lead_q
);
    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);
    localparam logic [DIV_W-1:0] PIPE_D  = DIV_W'(SE_PIPE);

    // A configuration is usable when it has a chain length, a divider of at
    // least two, and room in the last shift interval for the early fall.
    always_comb begin
        cfg_ok = (cfg_len != '0) && (cfg_div >= DIV_MIN);
        if (cfg_pipe && (cfg_div <= PIPE_D)) begin
            cfg_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            div_q  <= DIV_MIN;
            los_q  <= 1'b0;
            lead_q <= '0;
        end else if (latch) begin
            len_q  <= cfg_len;
            div_q  <= cfg_div;
            los_q  <= cfg_los;
            lead_q <= cfg_pipe ? PIPE_D : '0;
        end
    end
endmodule

// File: rtl/seq_rate_div.sv
`timescale 1ns/1ps
module seq_rate_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic [DIV_W-1:0] cnt,
    output logic             tick
);
    // tick marks the final cycle of each divider interval
    assign tick = run && (cnt == div - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/seq_pulse_count.sv
`timescale 1ns/1ps
module seq_pulse_count #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/atspeed_scan_seq.sv
`timescale 1ns/1ps
module atspeed_scan_seq
    import scan_seq_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int DIV_W   = 4,
    parameter int SE_PIPE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_los,
    input  logic             cfg_pipe,
    output logic             scan_en,
    output logic             tclk_en,
    output logic             done,
    output logic [LEN_W-1:0] shift_cnt
);
    seq_state_e       state_q, state_d;
    logic             cfg_ok;
    logic             accept;
    logic [LEN_W-1:0] len_q;
    logic [DIV_W-1:0] div_q;
    logic             los_q;
    logic [DIV_W-1:0] lead_q;
    logic [DIV_W-1:0] div_cnt;
    logic             tick;
    logic             div_run;
    logic             div_clr;
    logic             last_pulse;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             early_fall;

    assign accept = (state_q == ST_IDLE) && start && !abort && cfg_ok;

    seq_cfg_hold #(.LEN_W(LEN_W), .DIV_W(DIV_W), .SE_PIPE(SE_PIPE)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch    (accept),
        .cfg_len  (cfg_len),
        .cfg_div  (cfg_div),
        .cfg_los  (cfg_los),
        .cfg_pipe (cfg_pipe),
        .cfg_ok   (cfg_ok),
        .len_q    (len_q),
        .div_q    (div_q),
        .los_q    (los_q),
        .lead_q   (lead_q)
    );

    assign div_run = (state_q == ST_LOAD) || (state_q == ST_LAUNCH) ||
                     (state_q == ST_UNLOAD);
    assign div_clr = (state_q != state_d);

    seq_rate_div #(.DIV_W(DIV_W)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .run   (div_run),
        .div   (div_q),
        .cnt   (div_cnt),
        .tick  (tick)
    );

    assign cnt_inc = tick && ((state_q == ST_LOAD) || (state_q == ST_UNLOAD));
    assign cnt_clr = accept || abort || (state_q == ST_CAPT);

    seq_pulse_count #(.LEN_W(LEN_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (shift_cnt)
    );

    assign last_pulse = (shift_cnt == len_q - 1'b1);

    // In the final load interval, the fall is announced lead_q cycles before
    // the interval ends; with lead_q zero this never triggers.
    assign early_fall = last_pulse && (div_cnt >= div_q - lead_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_LOAD;
            ST_LOAD:   if (tick && last_pulse) state_d = los_q ? ST_CAPT : ST_LAUNCH;
            ST_LAUNCH: if (tick) state_d = ST_CAPT;
            ST_CAPT:   state_d = ST_UNLOAD;
            ST_UNLOAD: if (tick && last_pulse) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d = ST_IDLE;
        end
    end

    // outputs
    always_comb begin
        scan_en = 1'b0;
        tclk_en = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LOAD: begin
                scan_en = !early_fall;
                tclk_en = tick;
            end
            ST_LAUNCH: tclk_en = tick;
            ST_CAPT:   tclk_en = 1'b1;
            ST_UNLOAD: begin
                scan_en = 1'b1;
                tclk_en = tick;
            end
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
        if (abort) begin
            scan_en = 1'b0;
            tclk_en = 1'b0;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!tclk_en && !scan_en && !done));

    a_r3_load_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> (shift_cnt < len_q));

    a_r4_loc_launch_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPT && !los_q && !abort) |->
            ($past(tclk_en) && !$past(scan_en)));

    a_r5_los_launch_is_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPT && los_q && !abort) |->
            ($past(tclk_en) && ($past(state_q) == ST_LOAD)));

    a_r4_capture_se_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPT) |-> !scan_en);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !abort && !tick) |=> (shift_cnt == $past(shift_cnt)));

    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_IDLE && shift_cnt == '0));
endmodule

// File: tb/atspeed_scan_seq_tb_top.sv
`timescale 1ns/1ps
module atspeed_scan_seq_tb_top;
    localparam int LEN_W   = 8;
    localparam int DIV_W   = 4;
    localparam int SE_PIPE = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             abort = 1'b0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             cfg_los = 1'b0;
    logic             cfg_pipe = 1'b0;
    logic             scan_en;
    logic             tclk_en;
    logic             done;
    logic [LEN_W-1:0] shift_cnt;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    atspeed_scan_seq #(.LEN_W(LEN_W), .DIV_W(DIV_W), .SE_PIPE(SE_PIPE)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .cfg_len   (cfg_len),
        .cfg_div   (cfg_div),
        .cfg_los   (cfg_los),
        .cfg_pipe  (cfg_pipe),
        .scan_en   (scan_en),
        .tclk_en   (tclk_en),
        .done      (done),
        .shift_cnt (shift_cnt)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic quiet_cycles(int n, string tag, int cnt_exp);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(scan_en == 1'b0, tag, "scan_en quiet", int'(scan_en), 0);
            chk(tclk_en == 1'b0, tag, "tclk_en quiet", int'(tclk_en), 0);
            chk(done == 1'b0, tag, "done quiet", int'(done), 0);
            chk(shift_cnt == LEN_W'(cnt_exp), tag, "shift_cnt held", int'(shift_cnt), cnt_exp);
        end
    endtask

    // One full test, every cycle compared with an arithmetic timeline.
    task automatic run_case(int L, int D, bit los, bit pipe);
        int pe;
        int t_last;
        int c_cyc;
        int u_end;
        int pulses;
        bit exp_se;
        bit exp_tc;
        bit exp_dn;
        string tag;
        pe = pipe ? SE_PIPE : 0;
        t_last = L * D - 1;
        c_cyc = los ? t_last + 1 : t_last + D + 1;
        u_end = c_cyc + L * D;
        pulses = 0;
        @(negedge clk);
        cfg_len = LEN_W'(L);
        cfg_div = DIV_W'(D);
        cfg_los = los;
        cfg_pipe = pipe;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i <= u_end + 3; i++) begin
            exp_se = 1'b0;
            exp_tc = 1'b0;
            exp_dn = 1'b0;
            tag = "R1";
            if (i <= t_last) begin
                tag = "R3";
                exp_tc = ((i + 1) % D) == 0;
                exp_se = !(i >= t_last + 1 - pe);
                if (pe != 0 && i >= t_last + 1 - pe) tag = "R6";
            end else if (!los && i < c_cyc) begin
                tag = "R4";
                exp_tc = (i == t_last + D);
            end else if (i == c_cyc) begin
                tag = los ? "R5" : "R4";
                exp_tc = 1'b1;
            end else if (i <= u_end) begin
                tag = "R7";
                exp_se = 1'b1;
                exp_tc = ((i - c_cyc) % D) == 0;
            end else if (i == u_end + 1) begin
                tag = "R8";
                exp_dn = 1'b1;
                chk(shift_cnt == LEN_W'(L), "R8", "shift_cnt at done", int'(shift_cnt), L);
            end
            chk(scan_en == exp_se, tag, "scan_en", int'(scan_en), int'(exp_se));
            chk(tclk_en == exp_tc, tag, "tclk_en", int'(tclk_en), int'(exp_tc));
            chk(done == exp_dn, tag, "done", int'(done), int'(exp_dn));
            if (tclk_en) pulses++;
            // R9 and R2: poke start and alter cfg while busy
            start = (i == 1) || (i == c_cyc + 2);
            cfg_len = (i == 1) ? LEN_W'(L + 1) : LEN_W'(L);
            cfg_los = (i == 1) ? !los : los;
            @(negedge clk);
        end
        start = 1'b0;
        chk(pulses == (los ? 2 * L + 1 : 2 * L + 2), "R9", "pulse total", pulses,
            los ? 2 * L + 1 : 2 * L + 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        quiet_cycles(2, "R1", 0);

        // R2: invalid configurations are ignored
        @(negedge clk);
        cfg_len = '0; cfg_div = 4'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        quiet_cycles(3, "R2", 0);
        cfg_len = 8'd2; cfg_div = 4'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        quiet_cycles(3, "R2", 0);

        // R10: abort during load
        cfg_len = 8'd3; cfg_div = 4'd3; cfg_los = 1'b0; cfg_pipe = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        abort = 1'b1;
        #1;
        chk(scan_en == 1'b0, "R10", "scan_en in abort cycle", int'(scan_en), 0);
        chk(tclk_en == 1'b0, "R10", "tclk_en in abort cycle", int'(tclk_en), 0);
        @(negedge clk);
        abort = 1'b0;
        #1;
        chk(shift_cnt == '0, "R10", "shift_cnt after abort", int'(shift_cnt), 0);
        quiet_cycles(4, "R10", 0);

        // R10: abort on the capture cycle of launch-on-shift (L=2, D=2, C=4)
        cfg_len = 8'd2; cfg_div = 4'd2; cfg_los = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        abort = 1'b1;
        #1;
        chk(tclk_en == 1'b0, "R10", "capture pulse suppressed", int'(tclk_en), 0);
        chk(scan_en == 1'b0, "R10", "scan_en on aborted capture", int'(scan_en), 0);
        @(negedge clk);
        abort = 1'b0;
        quiet_cycles(4, "R10", 0);

        // sweep over mode, pipeline option, length and divider
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int l = 1; l <= 3; l++) begin
                    for (int d = 2; d <= 4; d++) begin
                        run_case(l, d, bit'(m), bit'(p));
                    end
                end
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule